// File: doc/BRIEF.md
# Sixteen-bit capture/reload timer-counter

This block is a 16-bit up/down timer-counter steered by an 8-bit control register. It steps either on system clock ticks (divided by 1 or by 12) or on falling edges of a count pin. When the count rolls over, the block reloads it from a 16-bit capture/reload register. A falling edge on a trigger pin can copy the live count into that same register (capture mode) or force an early reload (reload mode). In split-direction mode the trigger pin sets the counting direction instead: high counts up, low counts down. The trigger flag then toggles on every roll and serves as a seventeenth count bit.

Software reaches the three registers through a simple word-wide bus with a write strobe and an address. Read data comes back combinationally for the address presented. Both pins pass through a two-flop synchronizer before any level or edge is used. The block can also drive the count pin as a 50% duty square wave that toggles on each roll. In that mode rolls do not raise the overflow flag. The interrupt request is the OR of the two flags, gated by an enable input.

Top module: `cr_timer16`

## Requirements
- R1: After reset, every register reads 0, and `cnt_pin_out`, `cnt_pin_oe` and `irq` are low.
- R2: Address 0 reads the control byte in bits 7:0 with zeros above it. Address 1 reads the count, address 2 reads the capture/reload register, and address 3 reads 0. A bus write to addresses 0 to 2 loads that register on the next clock edge. Control bit positions: 7 overflow flag, 6 trigger flag, 5 clock-output enable, 4 split-direction enable, 3 trigger enable, 2 run, 1 external count select, 0 capture mode.
- R3: With run=1, external count select=0, split-direction off and `div12_sel`=0, the count rises by one per clock, starting one clock after the control write. With run=0 and trigger enable=0, the count holds.
- R4: An upward step from FFFFh loads the count from the capture/reload register and sets the overflow flag. The flag stays set until software writes the control register.
- R5: With `div12_sel`=1, the timer takes one step every 12 clocks. The first step comes 12 clocks after run becomes active.
- R6: Split-direction mode is split-direction enable=1 with capture mode=0. In this mode the count goes up while the synchronized trigger pin is high and down while it is low. A downward step taken when the count equals the capture/reload register loads FFFFh and sets the overflow flag.
- R7: In split-direction mode, the trigger flag inverts on every roll in either direction, and the trigger flag does not drive `irq`.
- R8: With capture mode=1 and trigger enable=1, a trigger-pin falling edge copies the count into the capture/reload register and sets the trigger flag. The count itself is unchanged.
- R9: With capture mode=0, split-direction enable=0 and trigger enable=1, a trigger-pin falling edge loads the count from the capture/reload register and sets the trigger flag.
- R10: With trigger enable=0, a trigger-pin falling edge changes neither the count, the capture/reload register nor either flag.
- R11: With external count select=1 and run=1, each falling edge on the count pin advances the count by one.
- R12: With clock-output enable=1 and external count select=0, `cnt_pin_oe` is 1 and `cnt_pin_out` inverts on every roll, and rolls leave the overflow flag clear. Otherwise `cnt_pin_oe` is 0.
- R13: `irq` equals `irq_en` AND (overflow flag OR trigger flag outside split-direction mode). Writing 1 to the trigger flag therefore raises `irq` when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 control, 1 count, 2 capture/reload) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| div12_sel | input | 1 | Timer prescale: 0 divide by 1, 1 divide by 12 |
| irq_en | input | 1 | Interrupt enable |
| cnt_pin_in | input | 1 | Count pin input (event source) |
| trig_pin_in | input | 1 | Trigger / direction pin |
| cnt_pin_out | output | 1 | Square-wave output value for the count pin |
| cnt_pin_oe | output | 1 | Output enable for the count pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the roll boundaries: FFFFh going up, and the reload value going down. A design that compares against the wrong bound, or loads the wrong value on a roll, ends a vector on a count off by one step or off by the whole reload value. It also looks at which flag each mode moves. A split-direction roll that sets the trigger flag instead of inverting it, or a clock-output roll that still sets the overflow flag, shows up as wrong flag bits and a spurious `irq`. Trigger edges are driven with the trigger enable both set and clear, and in capture and in reload mode. A design that lets a disabled edge through, or that moves the count during a capture, corrupts one of the two 16-bit registers.

// File: rtl/cr_timer16_pkg.sv
// Shared types for the capture/reload timer.
// Assumes a bus at least 8 bits wide so the control byte fits in one word.
package cr_timer16_pkg;

    // Control byte; field order is the bit order seen on the bus (bit 7 first).
    typedef struct packed {
        logic ovf;      // overflow flag
        logic trg;      // trigger flag / 17th bit
        logic clk_oe;   // square-wave output enable
        logic split;    // split-direction enable
        logic trg_en;   // trigger pin enable
        logic run;      // run
        logic ext_cnt;  // count pin events instead of clocks
        logic cap;      // capture mode (1) or reload mode (0)
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_CRG = 2'd2;

endpackage

// File: rtl/crt_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes pins are slow relative to clk; reset value is 0 so an idle-high
// pin yields a rising edge only, never a falling one.
module crt_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= pin;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/crt_prescale.sv
// Timer tick generator: one tick per clock, or one per DIV_N clocks.
// Assumes the phase counter should restart from zero whenever disabled.
module crt_prescale #(
    parameter int DIV_N = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic div_sel,
    output logic tick
);
    localparam int PW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV_N - 1);

    logic [PW-1:0] phase;

    // Advance the divide phase while enabled, wrapping at DIV_N.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = enable & (div_sel ? (phase == LAST) : 1'b1);
endmodule

// File: rtl/crt_count_core.sv
// Up/down counter with load, forced reload and roll handling.
// Up roll happens at all-ones and loads reload_val; down roll happens at
// reload_val and loads all-ones. Priority: load, forced reload, step.
module crt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         reload_now,
    input  logic [W-1:0] reload_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] count,
    output logic         roll
);
    localparam logic [W-1:0] ALL1 = '1;

    logic roll_raw;
    logic [W-1:0] nxt;

    // Detect the roll point for the current direction.
    always_comb begin
        roll_raw = step & (down ? (count == reload_val) : (count == ALL1));
        roll     = roll_raw & ~ld & ~reload_now;
    end

    // Select the next count value by priority.
    always_comb begin
        if (ld)              nxt = ld_val;
        else if (reload_now) nxt = reload_val;
        else if (roll_raw)   nxt = down ? ALL1 : reload_val;
        else if (step)       nxt = down ? count - 1'b1 : count + 1'b1;
        else                 nxt = count;
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end
endmodule

// File: rtl/cr_timer16.sv
// Capture/reload timer-counter top: register bank, pin synchronizers,
// event selection, flag logic, square-wave output and interrupt.
// Assumes the bus is combinational-read, single-cycle write, and that
// hardware flag events in the write cycle apply on top of the written value.
module cr_timer16
    import cr_timer16_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_N     = 12,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             div12_sel,
    input  logic             irq_en,
    input  logic             cnt_pin_in,
    input  logic             trig_pin_in,
    output logic             cnt_pin_out,
    output logic             cnt_pin_oe,
    output logic             irq
);
    localparam int NPIN = 2;
    localparam int PCNT = 0;
    localparam int PTRG = 1;

    ctl_t             ctl_q, ctl_d;
    logic [CNT_W-1:0] crg_q;
    logic [CNT_W-1:0] count;
    logic [NPIN-1:0]  pin_lvl, pin_prev, pin_fall;
    logic             wr_ctl, wr_cnt, wr_crg;
    logic             split_mode, clkout_mode, down;
    logic             psc_tick, step, roll;
    logic             trig_evt, do_capture, do_reload;
    logic             pin_q;

    // Bring both pins into the clock domain.
    crt_pin_sync #(.W(NPIN), .STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({trig_pin_in, cnt_pin_in}),
        .lvl  (pin_lvl)
    );

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= '0;
        else        pin_prev <= pin_lvl;
    end

    // Falling edge per pin.
    always_comb pin_fall = pin_prev & ~pin_lvl;

    // Decode bus writes and mode conditions.
    always_comb begin
        wr_ctl      = bus_wr && (bus_addr == ADDR_CTL);
        wr_cnt      = bus_wr && (bus_addr == ADDR_CNT);
        wr_crg      = bus_wr && (bus_addr == ADDR_CRG);
        split_mode  = ctl_q.split & ~ctl_q.cap;
        clkout_mode = ctl_q.clk_oe & ~ctl_q.ext_cnt;
        down        = split_mode & ~pin_lvl[PTRG];
        trig_evt    = ctl_q.trg_en & pin_fall[PTRG];
        do_capture  = trig_evt & ctl_q.cap;
        do_reload   = trig_evt & ~ctl_q.cap & ~ctl_q.split;
    end

    crt_prescale #(.DIV_N(DIV_N)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctl_q.run & ~ctl_q.ext_cnt),
        .div_sel(div12_sel),
        .tick   (psc_tick)
    );

    // Pick the step source: count-pin edges or prescaled clock.
    always_comb step = ctl_q.ext_cnt ? (ctl_q.run & pin_fall[PCNT]) : psc_tick;

    crt_count_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (wr_cnt),
        .ld_val    (bus_wdata),
        .reload_now(do_reload),
        .reload_val(crg_q),
        .step      (step),
        .down      (down),
        .count     (count),
        .roll      (roll)
    );

    // Next control byte: bus write, then hardware set and toggle on top.
    always_comb begin
        ctl_d     = wr_ctl ? ctl_t'(bus_wdata[CTL_W-1:0]) : ctl_q;
        ctl_d.ovf = ctl_d.ovf | (roll & ~clkout_mode);
        ctl_d.trg = (ctl_d.trg | (trig_evt & ~split_mode)) ^ (roll & split_mode);
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Capture/reload register: bus write wins over capture.
    always_ff @(posedge clk) begin
        if (!rst_n)          crg_q <= '0;
        else if (wr_crg)     crg_q <= bus_wdata;
        else if (do_capture) crg_q <= count;
    end

    // Square-wave output toggles on every roll in clock-output mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pin_q <= 1'b0;
        else if (roll && clkout_mode)  pin_q <= ~pin_q;
    end

    assign cnt_pin_out = pin_q;
    assign cnt_pin_oe  = clkout_mode;
    assign irq         = irq_en & (ctl_q.ovf | (ctl_q.trg & ~split_mode));

    // Read mux.
    always_comb begin
        unique case (bus_addr)
            ADDR_CTL: bus_rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
            ADDR_CNT: bus_rdata = count;
            ADDR_CRG: bus_rdata = crg_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cr_timer16_chk.sv
// Property checker for cr_timer16, attached by bind below.
// Assumes the control bit order of the package (bit 7 overflow .. bit 0 capture).
module cr_timer16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [7:0]       ctl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] crg,
    input logic             irq,
    input logic             cnt_pin_oe,
    input logic             cnt_pin_out
);
    // R3: stopped with trigger disabled and no bus activity, count holds.
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[2] && !ctl[3] && !bus_wr) |=> $stable(count));

    // R4: overflow flag is sticky until a control write.
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[7] && !(bus_wr && bus_addr == 2'd0)) |=> ctl[7]);

    // R8: capture mode never moves a stopped count.
    a_r8_capture_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && !ctl[2] && !bus_wr) |=> $stable(count));

    // R10: with trigger disabled, the capture/reload register only moves on a write.
    a_r10_crg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[3] && !bus_wr) |=> $stable(crg));

    // R12: the pin value is frozen while not driven.
    a_r12_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_pin_oe |=> $stable(cnt_pin_out));

    // R12: clock-output rolls never raise the overflow flag.
    a_r12_no_flag_clkout: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pin_oe && !ctl[7] && !(bus_wr && bus_addr == 2'd0)) |=> !ctl[7]);

    // R13: an interrupt needs a flag behind it.
    a_r13_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl[7] || ctl[6]));
endmodule

bind cr_timer16 cr_timer16_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ctl        (ctl_q),
    .count      (count),
    .crg        (crg_q),
    .irq        (irq),
    .cnt_pin_oe (cnt_pin_oe),
    .cnt_pin_out(cnt_pin_out)
);

// File: tb/cr_timer16_tb_top.sv
// Self-checking bench for cr_timer16: vector table, then directed tests.
module cr_timer16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        div12_sel = 1'b0;
    logic        irq_en = 1'b0;
    logic        cnt_pin_in = 1'b1;
    logic        trig_pin_in = 1'b1;
    logic        cnt_pin_out, cnt_pin_oe, irq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cr_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div12_sel(div12_sel),
        .irq_en(irq_en), .cnt_pin_in(cnt_pin_in), .trig_pin_in(trig_pin_in),
        .cnt_pin_out(cnt_pin_out), .cnt_pin_oe(cnt_pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] creg;
        logic [15:0] init;
        logic        div12;
        logic        trig;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic [1:0]  exp_flags;   // {overflow, trigger}
        logic        exp_tgl;     // parity of pin toggles
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 16'h0000, 16'h0010, 1'b0, 1'b0, 8'd5,  16'h0015, 2'b00, 1'b0},
        '{8'h04, 16'h1234, 16'hFFFE, 1'b0, 1'b0, 8'd3,  16'h1235, 2'b10, 1'b0},
        '{8'h04, 16'h0000, 16'h0100, 1'b1, 1'b0, 8'd25, 16'h0102, 2'b00, 1'b0},
        '{8'h14, 16'h0005, 16'h0007, 1'b0, 1'b0, 8'd4,  16'hFFFE, 2'b11, 1'b0},
        '{8'h14, 16'h0020, 16'hFFFF, 1'b0, 1'b1, 8'd2,  16'h0021, 2'b11, 1'b0},
        '{8'h24, 16'hFFFE, 16'hFFFF, 1'b0, 1'b0, 8'd2,  16'hFFFF, 2'b00, 1'b1},
        '{8'h00, 16'h0000, 16'h4321, 1'b0, 1'b0, 8'd10, 16'h4321, 2'b00, 1'b0}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3 up count";
            1: return "R4 overflow reload";
            2: return "R5 divide by 12";
            3: return "R6 split down";
            4: return "R7 split up toggle";
            5: return "R12 clock output";
            default: return "R3 stopped hold";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Enter and leave at a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic        pin0;
        vec_t        v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 address map
        rd(2'd0, r); chk("R1 ctrl", r, 0);
        rd(2'd1, r); chk("R1 count", r, 0);
        rd(2'd2, r); chk("R1 creg", r, 0);
        chk("R1 pins/irq", {cnt_pin_out, cnt_pin_oe, irq}, 0);
        bus_write(2'd2, 16'hBEEF);
        rd(2'd2, r); chk("R2 creg readback", r, 16'hBEEF);
        rd(2'd3, r); chk("R2 unused address", r, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            div12_sel = v.div12;
            trig_pin_in = v.trig;
            bus_write(2'd0, 16'h0000);
            bus_write(2'd1, v.init);
            bus_write(2'd2, v.creg);
            wait_cyc(4);
            pin0 = cnt_pin_out;
            bus_write(2'd0, {8'h00, v.ctrl});
            wait_cyc(int'(v.n));
            rd(2'd1, r); chk({vtag(i), " count"}, r, v.exp_cnt);
            rd(2'd0, r); chk({vtag(i), " flags"}, r[7:6], v.exp_flags);
            chk({vtag(i), " pin"}, cnt_pin_out, pin0 ^ v.exp_tgl);
        end
        div12_sel = 1'b0;
        bus_write(2'd0, 16'h0000);

        // R8 capture on trigger fall
        trig_pin_in = 1'b1; wait_cyc(4);
        bus_write(2'd1, 16'h5555);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd0, 16'h0009);
        irq_en = 1'b1;
        trig_pin_in = 1'b0; wait_cyc(5);
        rd(2'd2, r); chk("R8 captured value", r, 16'h5555);
        rd(2'd1, r); chk("R8 count unchanged", r, 16'h5555);
        rd(2'd0, r); chk("R8 trigger flag", r, 16'h0049);
        chk("R13 irq from trigger flag", irq, 1'b1);
        irq_en = 1'b0;
        trig_pin_in = 1'b1; wait_cyc(4);

        // R9 reload on trigger fall
        bus_write(2'd0, 16'h0000);
        bus_write(2'd2, 16'h0ABC);
        bus_write(2'd1, 16'h0001);
        bus_write(2'd0, 16'h0008);
        trig_pin_in = 1'b0; wait_cyc(5);
        rd(2'd1, r); chk("R9 reloaded count", r, 16'h0ABC);
        rd(2'd0, r); chk("R9 trigger flag", r, 16'h0048);
        trig_pin_in = 1'b1; wait_cyc(4);

        // R10 trigger ignored when disabled
        bus_write(2'd0, 16'h0001);
        bus_write(2'd1, 16'h7777);
        bus_write(2'd2, 16'h1111);
        trig_pin_in = 1'b0; wait_cyc(5);
        rd(2'd2, r); chk("R10 creg untouched", r, 16'h1111);
        rd(2'd1, r); chk("R10 count untouched", r, 16'h7777);
        rd(2'd0, r); chk("R10 flags untouched", r, 16'h0001);
        trig_pin_in = 1'b1; wait_cyc(4);

        // R11 event counting on count pin
        bus_write(2'd0, 16'h0000);
        bus_write(2'd1, 16'h0000);
        bus_write(2'd0, 16'h0006);
        for (int k = 0; k < 3; k++) begin
            cnt_pin_in = 1'b0; wait_cyc(4);
            cnt_pin_in = 1'b1; wait_cyc(4);
        end
        rd(2'd1, r); chk("R11 event count", r, 16'h0003);

        // R12 output enable follows mode
        bus_write(2'd0, 16'h0026);
        chk("R12 oe off with external count", cnt_pin_oe, 1'b0);
        bus_write(2'd0, 16'h0020);
        chk("R12 oe on in clock output", cnt_pin_oe, 1'b1);
        bus_write(2'd0, 16'h0000);
        chk("R12 oe off", cnt_pin_oe, 1'b0);

        // R13 forced interrupt and gating
        irq_en = 1'b1;
        bus_write(2'd0, 16'h0040);
        chk("R13 forced irq", irq, 1'b1);
        irq_en = 1'b0; #1;
        chk("R13 irq gated off", irq, 1'b0);
        irq_en = 1'b1;
        bus_write(2'd0, 16'h0050);
        chk("R7 no irq in split mode", irq, 1'b0);
        bus_write(2'd0, 16'h0080);
        chk("R13 irq from overflow flag", irq, 1'b1);
        irq_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule